// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block moves pixel or command data between 32-bit words on the chip side and an external display controller on an 8080-style parallel bus. Each transfer takes its settings when it starts: read or write, command or data, beat width (8 or 16 bits), the number of beats, a tick divider, and a strobe timing pair for each direction. During a write, each 32-bit word taken from the write FIFO is cut into 4 narrow beats or 2 wide beats, least-significant part first. During a read, incoming beats are packed back into 32-bit words in the same order.

Every beat has three parts. A one-tick setup comes first, with the data driven and the strobe still high. The active phase follows, with the strobe low for TW0 ticks. A recovery phase of TW1-1 ticks closes the beat. A tick is the clock divided by D, where D runs from 1 to 8. Chip select is low for the whole transfer. The data/command line follows the select bit. A done flag rises once the programmed number of beats has completed.

Top module: `dispbus_engine`

## Requirements
- R1: Out of reset and outside a transfer, busCsN, busWrN and busRdN are high, busDout is zero and done is high. A strobe is never low while busCsN is high.
- R2: A start is refused when the TW1 field of the selected direction is below 2 (fewer than 3 ticks). After a refused start busCsN stays high, no strobe pulses and done stays high.
- R3: With fields TW0 (cfgTw0*) and DIV (cfgDiv), a strobe stays low for (TW0+1)*(DIV+1) clock cycles. Within one word, consecutive strobe falling edges are (TW0+TW1+2)*(DIV+1) cycles apart, where TW1 is the cfgTw1* field.
- R4: A transfer issues exactly cfgBeats+1 strobe pulses. Done is low while the transfer runs, and done goes high and busCsN is released when it finishes.
- R5: cfgWide=0 selects 8-bit beats: 4 per word, bits [7:0] first, driven on busDout[7:0] with the upper byte zero. cfgWide=1 selects 16-bit beats: 2 per word, bits [15:0] first.
- R6: busDc equals isData as latched at start (0 = command, 1 = data) and holds steady throughout the transfer.
- R7: On reads, busDin is sampled one tick after the strobe rises. Beats are packed least-significant part first into rdWord. A word left partial at the end of the transfer is delivered with its unfilled upper bits zero.
- R8: During a write with no word held, busWrN stays high and busCsN stays low until the write FIFO supplies a word.
- R9: While rdValid is high and rdReady is low, rdWord holds. No further read beat starts until that word is taken.
- R10: busRdN pulses only in read transfers and busWrN only in write transfers. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a transfer when idle |
| isRead | input | 1 | 1 = read transfer, 0 = write transfer |
| isData | input | 1 | Data/command select, 1 = data |
| cfgWide | input | 1 | 1 = 16-bit beats, 0 = 8-bit beats |
| cfgDiv | input | 3 | Tick divider minus one |
| cfgTw0Rd | input | 4 | Read strobe-active ticks minus one |
| cfgTw1Rd | input | 6 | Read rest-of-cycle ticks minus one |
| cfgTw0Wr | input | 4 | Write strobe-active ticks minus one |
| cfgTw1Wr | input | 6 | Write rest-of-cycle ticks minus one |
| cfgBeats | input | 18 | Number of beats minus one |
| wrValid | input | 1 | Write FIFO has a word |
| wrWord | input | 32 | Write FIFO head word |
| wrReady | output | 1 | Word taken from write FIFO this cycle when wrValid |
| rdValid | output | 1 | Packed read word available |
| rdWord | output | 32 | Packed read word |
| rdReady | input | 1 | Read FIFO accepts rdWord |
| busCsN | output | 1 | Chip select, active low |
| busWrN | output | 1 | Write strobe, active low |
| busRdN | output | 1 | Read strobe, active low |
| busDc | output | 1 | Data/command line |
| busDout | output | 16 | Bus write data |
| busDin | input | 16 | Bus read data |
| done | output | 1 | All programmed beats complete |

## Verification
Two events can land in the same clock edge: the beat that uses the last slice of a held word empties the holding register, and the sequencer returns to setup. The next word is therefore taken from the FIFO while the sequencer is already waiting for it. Multi-word writes keep wrValid high so that this boundary is crossed repeatedly. The beat values on the bus are then compared in order, with no slice repeated or skipped. The read side meets a matching case when a completed word is pushed while the consumer holds rdReady low. The bench counts read strobes to confirm that the sequencer stops at setup until that word is taken.

// File: rtl/dispbus_pkg.sv
package dispbus_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;    // transfer accepted: reset split/pack state
    logic sample;   // capture busDin into the pack register
    logic beatEnd;  // current beat finished
    logic finish;   // current beat is the final one
  } dpCtl_t;
endpackage

// File: rtl/dispbus_tick.sv
module dispbus_tick #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (!en || tick)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dispbus_ctrl.sv
module dispbus_ctrl
  import dispbus_pkg::*;
#(
  parameter int TW0_W   = 4,
  parameter int TW1_W   = 6,
  parameter int LEN_W   = 18,
  parameter int DIV_W   = 3,
  parameter int TW1_MIN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isRead,
  input  logic             isData,
  input  logic             cfgWide,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [TW0_W-1:0] cfgTw0Rd,
  input  logic [TW1_W-1:0] cfgTw1Rd,
  input  logic [TW0_W-1:0] cfgTw0Wr,
  input  logic [TW1_W-1:0] cfgTw1Wr,
  input  logic [LEN_W-1:0] cfgBeats,
  input  logic             haveWord,
  input  logic             outFull,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             rdMode,
  output logic             wideMode,
  output logic             dcMode,
  output logic             strobeAct,
  output logic             done
);
  localparam int CNT_W = (TW0_W > TW1_W) ? TW0_W : TW1_W;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [TW0_W-1:0] tw0L;
  logic [TW1_W-1:0] tw1L;
  logic [DIV_W-1:0] divL;
  logic [LEN_W-1:0] beatsLeft;
  logic             tick;
  logic             startOk;
  logic [CNT_W-1:0] recInit;
  logic             canGo;

  assign busy      = (phase != PH_IDLE);
  assign strobeAct = (phase == PH_ACT);
  assign startOk   = start && !busy &&
                     ((isRead ? cfgTw1Rd : cfgTw1Wr) >= TW1_W'(TW1_MIN));
  assign recInit   = CNT_W'(tw1L - 1'b1);
  assign canGo     = rdMode ? !outFull : haveWord;

  dispbus_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rstN(rstN), .en(busy), .div(divL), .tick(tick)
  );

  always_comb begin
    ctl.clear   = startOk;
    ctl.sample  = tick && (phase == PH_REC) && (cnt == recInit) && rdMode;
    ctl.beatEnd = tick && (phase == PH_REC) && (cnt == '0);
    ctl.finish  = ctl.beatEnd && (beatsLeft == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      tw0L      <= '0;
      tw1L      <= '0;
      divL      <= '0;
      beatsLeft <= '0;
      rdMode    <= 1'b0;
      wideMode  <= 1'b0;
      dcMode    <= 1'b1;
      done      <= 1'b1;
    end else if (startOk) begin
      phase     <= PH_SETUP;
      tw0L      <= isRead ? cfgTw0Rd : cfgTw0Wr;
      tw1L      <= isRead ? cfgTw1Rd : cfgTw1Wr;
      divL      <= cfgDiv;
      beatsLeft <= cfgBeats;
      rdMode    <= isRead;
      wideMode  <= cfgWide;
      dcMode    <= isData;
      done      <= 1'b0;
    end else if (tick) begin
      unique case (phase)
        PH_SETUP: if (canGo) begin
          phase <= PH_ACT;
          cnt   <= CNT_W'(tw0L);
        end
        PH_ACT: if (cnt == '0) begin
          phase <= PH_REC;
          cnt   <= recInit;
        end else cnt <= cnt - 1'b1;
        PH_REC: if (cnt == '0) begin
          if (beatsLeft == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            beatsLeft <= beatsLeft - 1'b1;
            phase     <= PH_SETUP;
          end
        end else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dispbus_dp.sv
module dispbus_dp
  import dispbus_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              busy,
  input  logic              rdMode,
  input  logic              wideMode,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrWord,
  output logic              wrReady,
  output logic              haveWord,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdWord,
  input  logic [BUS_W-1:0]  busDin,
  output logic [BUS_W-1:0]  busDout
);
  localparam int NARROW_W = BUS_W / 2;
  localparam int SUBS_MAX = WORD_W / NARROW_W;
  localparam int SUB_W    = $clog2(SUBS_MAX);
  localparam int SHIFT_W  = $clog2(WORD_W) + 1;

  logic [SUB_W-1:0]   subIdx;
  logic [SUB_W-1:0]   lastSub;
  logic [WORD_W-1:0]  wordReg;
  logic [WORD_W-1:0]  packReg;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [WORD_W-1:0]  curSlice;
  logic [WORD_W-1:0]  inSlice;

  assign lastSub  = wideMode ? SUB_W'(WORD_W / BUS_W - 1) : SUB_W'(SUBS_MAX - 1);
  assign shiftAmt = wideMode ? SHIFT_W'(subIdx) * SHIFT_W'(BUS_W)
                             : SHIFT_W'(subIdx) * SHIFT_W'(NARROW_W);
  assign curSlice = wordReg >> shiftAmt;
  assign inSlice  = wideMode ? (WORD_W'(busDin) << shiftAmt)
                             : (WORD_W'(busDin[NARROW_W-1:0]) << shiftAmt);
  assign wrReady  = busy && !rdMode && !haveWord;

  always_comb begin
    busDout = '0;
    if (busy && !rdMode && haveWord) begin
      if (wideMode) busDout = curSlice[BUS_W-1:0];
      else          busDout = BUS_W'(curSlice[NARROW_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subIdx   <= '0;
      wordReg  <= '0;
      haveWord <= 1'b0;
      packReg  <= '0;
      rdValid  <= 1'b0;
      rdWord   <= '0;
    end else begin
      if (rdValid && rdReady) rdValid <= 1'b0;
      if (ctl.clear) begin
        subIdx   <= '0;
        haveWord <= 1'b0;
        packReg  <= '0;
      end else begin
        if (wrReady && wrValid) begin
          wordReg  <= wrWord;
          haveWord <= 1'b1;
        end
        if (ctl.sample) packReg <= packReg | inSlice;
        if (ctl.beatEnd) begin
          if (subIdx == lastSub || ctl.finish) begin
            subIdx   <= '0;
            haveWord <= 1'b0;
            if (rdMode) begin
              rdValid <= 1'b1;
              rdWord  <= packReg;
              packReg <= '0;
            end
          end else begin
            subIdx <= subIdx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dispbus_engine.sv
module dispbus_engine
  import dispbus_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16,
  parameter int TW0_W  = 4,
  parameter int TW1_W  = 6,
  parameter int LEN_W  = 18,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isRead,
  input  logic              isData,
  input  logic              cfgWide,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [TW0_W-1:0]  cfgTw0Rd,
  input  logic [TW1_W-1:0]  cfgTw1Rd,
  input  logic [TW0_W-1:0]  cfgTw0Wr,
  input  logic [TW1_W-1:0]  cfgTw1Wr,
  input  logic [LEN_W-1:0]  cfgBeats,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrWord,
  output logic              wrReady,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdWord,
  input  logic              rdReady,
  output logic              busCsN,
  output logic              busWrN,
  output logic              busRdN,
  output logic              busDc,
  output logic [BUS_W-1:0]  busDout,
  input  logic [BUS_W-1:0]  busDin,
  output logic              done
);
  dpCtl_t ctl;
  logic   busy, rdMode, wideMode, dcMode, strobeAct, haveWord;

  dispbus_ctrl #(
    .TW0_W(TW0_W), .TW1_W(TW1_W), .LEN_W(LEN_W), .DIV_W(DIV_W), .TW1_MIN(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead), .isData(isData),
    .cfgWide(cfgWide), .cfgDiv(cfgDiv), .cfgTw0Rd(cfgTw0Rd), .cfgTw1Rd(cfgTw1Rd),
    .cfgTw0Wr(cfgTw0Wr), .cfgTw1Wr(cfgTw1Wr), .cfgBeats(cfgBeats),
    .haveWord(haveWord), .outFull(rdValid), .ctl(ctl), .busy(busy),
    .rdMode(rdMode), .wideMode(wideMode), .dcMode(dcMode),
    .strobeAct(strobeAct), .done(done)
  );

  dispbus_dp #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .rdMode(rdMode),
    .wideMode(wideMode), .wrValid(wrValid), .wrWord(wrWord), .wrReady(wrReady),
    .haveWord(haveWord), .rdReady(rdReady), .rdValid(rdValid), .rdWord(rdWord),
    .busDin(busDin), .busDout(busDout)
  );

  assign busCsN = !busy;
  assign busWrN = !(strobeAct && !rdMode);
  assign busRdN = !(strobeAct && rdMode);
  assign busDc  = dcMode;
endmodule

// File: rtl/dispbus_chk.sv
module dispbus_chk #(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busCsN,
  input logic              busWrN,
  input logic              busRdN,
  input logic              busDc,
  input logic [BUS_W-1:0]  busDout,
  input logic              wrReady,
  input logic              rdValid,
  input logic              rdReady,
  input logic [WORD_W-1:0] rdWord,
  input logic              done
);
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrN || !busRdN) |-> !busCsN);                                   // R1
  AST_IDLE_DOUT: assert property (@(posedge clk) disable iff (!rstN)
    busCsN |-> (busDout == '0));                                          // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busCsN);                                                     // R4
  AST_DC_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && $past(!busCsN)) |-> $stable(busDc));                      // R6
  AST_NO_WORD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> busWrN);                                                  // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdWord)));              // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!busWrN && !busRdN));                                               // R10
endmodule

bind dispbus_engine dispbus_chk #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .busCsN(busCsN), .busWrN(busWrN), .busRdN(busRdN),
  .busDc(busDc), .busDout(busDout), .wrReady(wrReady), .rdValid(rdValid),
  .rdReady(rdReady), .rdWord(rdWord), .done(done)
);

// File: tb/sim_dispbus_engine.sv
`timescale 1ns/1ps
module sim_dispbus_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 0, isRead = 0, isData = 1, cfgWide = 0;
  logic [2:0]  cfgDiv = 0;
  logic [3:0]  cfgTw0Rd = 0, cfgTw0Wr = 0;
  logic [5:0]  cfgTw1Rd = 2, cfgTw1Wr = 2;
  logic [17:0] cfgBeats = 0;
  logic        wrValid, wrReady, rdValid, rdReady = 1;
  logic [31:0] wrWord, rdWord;
  logic        busCsN, busWrN, busRdN, busDc, done;
  logic [15:0] busDout, busDin = 0;

  int checks = 0, errors = 0;
  logic [31:0] wq [0:7];
  int wrIdx = 0, wrAvail = 0;
  logic [15:0] wrLog [0:31];
  logic        dcLog [0:31];
  int wrCnt = 0, wrFalls = 0, rdFalls = 0;
  logic [31:0] rdLog [0:15];
  int rdCnt = 0;
  time fallT [0:3];
  time riseT0;

  always #4 clk = ~clk;

  assign wrValid = (wrIdx < wrAvail);
  assign wrWord  = wq[wrIdx[2:0]];
  always @(posedge clk) if (wrValid && wrReady) wrIdx <= wrIdx + 1;

  dispbus_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead), .isData(isData),
    .cfgWide(cfgWide), .cfgDiv(cfgDiv), .cfgTw0Rd(cfgTw0Rd), .cfgTw1Rd(cfgTw1Rd),
    .cfgTw0Wr(cfgTw0Wr), .cfgTw1Wr(cfgTw1Wr), .cfgBeats(cfgBeats),
    .wrValid(wrValid), .wrWord(wrWord), .wrReady(wrReady), .rdValid(rdValid),
    .rdWord(rdWord), .rdReady(rdReady), .busCsN(busCsN), .busWrN(busWrN),
    .busRdN(busRdN), .busDc(busDc), .busDout(busDout), .busDin(busDin),
    .done(done)
  );

  function automatic logic [15:0] rdPat(int n);
    return 16'h1357 + 16'(n) * 16'h1111;
  endfunction

  always @(negedge busWrN) if (rstN) begin
    if (wrFalls < 4) fallT[wrFalls] = $time;
    wrFalls++;
  end
  always @(posedge busWrN) if (rstN) begin
    if (wrCnt == 0) riseT0 = $time;
    wrLog[wrCnt[4:0]] = busDout;
    dcLog[wrCnt[4:0]] = busDc;
    wrCnt++;
  end
  always @(negedge busRdN) if (rstN) begin
    busDin <= rdPat(rdFalls);
    rdFalls++;
  end
  always @(negedge clk) if (rstN && rdValid && rdReady) begin
    rdLog[rdCnt[3:0]] = rdWord;
    rdCnt++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearLogs();
    wrCnt = 0; wrFalls = 0; rdCnt = 0;
    @(posedge clk); #1 wrIdx = 0; wrAvail = 0;
  endtask

  task automatic kick(logic rd, logic dat, logic wide, int beats);
    @(posedge clk); #1;
    isRead = rd; isData = dat; cfgWide = wide; cfgBeats = 18'(beats); start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic waitDone();
    while (!done) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 csN", 32'(busCsN), 1);
    chk("R1 wrN", 32'(busWrN), 1);
    chk("R1 rdN", 32'(busRdN), 1);
    chk("R1 dout", 32'(busDout), 0);
    chk("R1 done", 32'(done), 1);
  endtask

  task automatic tWrite8();
    clearLogs();
    wq[0] = 32'h44332211; wq[1] = 32'h88776655; wrAvail = 2;
    cfgTw0Wr = 0; cfgTw1Wr = 2; cfgDiv = 0;
    kick(0, 1, 0, 7);
    @(negedge clk);
    chk("R4 done low while busy", 32'(done), 0);
    waitDone();
    chk("R4 beat count", wrCnt, 8);
    for (int i = 0; i < 8; i++)
      chk("R5 narrow beat LSB first", 32'(wrLog[i]), 32'(8'h11 * (i + 1)));
    chk("R6 data dc", 32'(dcLog[0]), 1);
    chk("R3 min TW1 period", 32'((fallT[1] - fallT[0]) / 8), 4);
    chk("R4 cs released", 32'(busCsN), 1);
    chk("R10 no read strobe in write", rdFalls, 0);
  endtask

  task automatic tWrite16Cmd();
    clearLogs();
    wq[0] = 32'hBEEFCAFE; wq[1] = 32'h12345678; wrAvail = 2;
    kick(0, 0, 1, 2);
    waitDone();
    chk("R4 partial beat count", wrCnt, 3);
    chk("R5 wide beat0", 32'(wrLog[0]), 32'hCAFE);
    chk("R5 wide beat1", 32'(wrLog[1]), 32'hBEEF);
    chk("R5 wide beat2", 32'(wrLog[2]), 32'h5678);
    chk("R6 command dc", 32'(dcLog[2]), 0);
  endtask

  task automatic tTiming();
    clearLogs();
    wq[0] = 32'hA5A55A5A; wrAvail = 1;
    cfgTw0Wr = 2; cfgTw1Wr = 4; cfgDiv = 1;
    kick(0, 1, 1, 1);
    waitDone();
    chk("R3 strobe width", 32'((riseT0 - fallT[0]) / 8), 6);
    chk("R3 beat period", 32'((fallT[1] - fallT[0]) / 8), 16);
    cfgTw0Wr = 0; cfgTw1Wr = 2; cfgDiv = 0;
  endtask

  task automatic tRefuse();
    clearLogs();
    wq[0] = 32'h1; wrAvail = 1;
    cfgTw1Wr = 1;
    kick(0, 1, 0, 3);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R2 cs stays high", 32'(busCsN), 1);
    chk("R2 done stays high", 32'(done), 1);
    chk("R2 no write strobe", wrFalls, 0);
    cfgTw1Wr = 2;
    cfgTw1Rd = 0;
    kick(1, 1, 0, 3);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R2 read refused", rdFalls, 0);
    cfgTw1Rd = 3;
  endtask

  task automatic tWrStall();
    clearLogs();
    wq[0] = 32'h0000BBAA;
    kick(0, 1, 0, 1);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R8 no strobe without word", wrFalls, 0);
    chk("R8 cs held", 32'(busCsN), 0);
    @(posedge clk); #1 wrAvail = 1;
    waitDone();
    chk("R8 resumes beat0", 32'(wrLog[0]), 32'hAA);
    chk("R8 resumes beat1", 32'(wrLog[1]), 32'hBB);
  endtask

  task automatic tRead16();
    int base;
    clearLogs();
    base = rdFalls;
    kick(1, 1, 1, 2);
    waitDone();
    @(negedge clk);
    chk("R7 read word count", rdCnt, 2);
    chk("R7 packed word", rdLog[0], {rdPat(base + 1), rdPat(base)});
    chk("R7 partial zero-filled", rdLog[1], {16'h0, rdPat(base + 2)});
    chk("R10 no write strobe in read", wrFalls, 0);
  endtask

  task automatic tRdStall();
    int base;
    clearLogs();
    base = rdFalls;
    @(posedge clk); #1 rdReady = 0;
    kick(1, 1, 0, 7);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R9 beats stop at full", rdFalls - base, 4);
    chk("R9 word waiting", 32'(rdValid), 1);
    chk("R9 word held", rdWord, {rdPat(base + 3)[7:0], rdPat(base + 2)[7:0],
                                 rdPat(base + 1)[7:0], rdPat(base)[7:0]});
    @(posedge clk); #1 rdReady = 1;
    waitDone();
    @(negedge clk);
    chk("R9 all beats after release", rdFalls - base, 8);
    chk("R7 narrow second word", rdLog[1], {rdPat(base + 7)[7:0], rdPat(base + 6)[7:0],
                                            rdPat(base + 5)[7:0], rdPat(base + 4)[7:0]});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tReset();
    tWrite8();
    tWrite16Cmd();
    tTiming();
    tRefuse();
    tWrStall();
    tRead16();
    tRdStall();
    tReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule